// File: doc/BRIEF.md
# Pulse-per-one uplink data encoder

This block turns a serial NRZ bit stream coming from a sensor into a pulse train. The pulse train drives a load-modulation switch across an antenna coil. A high level on the output closes the switch. The sensor supplies its data together with a data clock. The bit on the data line is taken at every rising edge of that data clock. A bit equal to one produces exactly one output pulse. A bit equal to zero produces none. The base station can then rebuild the stream by counting changes in the coil load.

Each pulse lasts one period of a pulse clock, and that clock is chosen at run time. It is either the system reference itself, a divide-by-`DIV_RATIO` version of it, or an externally supplied clock. Changing the pulse clock therefore changes the pulse width. The divided clock also leaves the block as an output for the sensor.

The whole block runs in the single system clock domain. The data clock, the data line and the external pulse clock each pass through a synchronizer chain. Rising edges are then detected on the synchronized copies.

Top module: `one_pulse_uplink_enc`

## Requirements
- R1: While `rst` is high, the block sets `enc_o` = 0 and `overrun_o` = 0 at each clock edge. It also sets `clk_div_o` = 1, because the divider phase is zero.
- R2: `clk_div_o` has a period of `DIV_RATIO` clocks. After reset it is high for the first `DIV_RATIO/2` clocks of each period and low for the rest.
- R3: The data clock, data and external clock inputs pass through `SYNC_STAGES` (2) flops, and rising edges are detected after that chain. At a synchronized data-clock rise, a data value of 1 requests one pulse and a value of 0 requests nothing.
- R4: With `src_sel_i` = 2'b00, or with the reserved code 2'b11, the pulse clock ticks on every system clock. A requested pulse then starts one clock after the request is latched and stays high for exactly one clock.
- R5: With `src_sel_i` = 2'b01, a pulse goes high at the same edge where `clk_div_o` rises. It stays high for `DIV_RATIO` clocks.
- R6: With `src_sel_i` = 2'b10, a pulse goes high at the edge that follows a synchronized rise of `ext_pclk_i`. It stays high until the edge that follows the next such rise.
- R7: After a pulse ends, `enc_o` stays low for at least one pulse-clock period before the next pulse starts. A one that arrives while a pulse is high is held in a one-deep pending slot and is sent later.
- R8: A one that arrives while a request is already waiting sets `overrun_o`. `overrun_o` stays set until reset.
- R9: When `src_sel_i` differs from its value in the previous clock, `enc_o` goes low at the next edge and any waiting request is discarded.
- R10: Reset is synchronous and active high. It clears the divider, the pending request, `overrun_o`, `enc_o` and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the reference) |
| rst | input | 1 | Synchronous reset, active high |
| data_clk_i | input | 1 | Data clock from the sensor, asynchronous |
| data_i | input | 1 | NRZ data from the sensor, asynchronous |
| ext_pclk_i | input | 1 | External pulse clock, asynchronous |
| src_sel_i | input | 2 | Pulse clock select: 00 system, 01 divided, 10 external, 11 system |
| clk_div_o | output | 1 | Divided clock for the sensor |
| enc_o | output | 1 | Encoded pulse output; high closes the modulation switch |
| overrun_o | output | 1 | Sticky flag: a request was lost |

## Verification
The checker watches several behaviours on every cycle:
- the reset values;
- that `overrun_o` never falls outside reset;
- that `enc_o` is low one clock after any change of select;
- that a pulse in system-clock mode lasts exactly one clock;
- that in divided mode a pulse can only start on a rising edge of `clk_div_o`.

Other behaviours can only be shown by the bench's scenarios. These are:
- the count of pulses against the count of ones sent;
- the measured width in the divided and external modes;
- the queuing of a second one;
- the overrun caused by a burst of ones;
- the dropping of a request that was waiting when the select changed.

// File: rtl/upenc_pkg.sv
package upenc_pkg;

    typedef enum logic [1:0] {
        PSRC_SYS  = 2'b00,
        PSRC_DIV  = 2'b01,
        PSRC_EXT  = 2'b10,
        PSRC_RSVD = 2'b11
    } psrc_e;

    // Bit positions inside the synchronized input vector
    localparam int IDX_DCLK = 0;
    localparam int IDX_DATA = 1;
    localparam int IDX_EXT  = 2;
    localparam int N_ASYNC  = 3;

    typedef struct packed {
        logic       act;   // pulse currently driven
        logic       req;   // one waiting for a pulse-clock tick
        logic       ovr;   // sticky lost-request flag
        logic [1:0] sel;   // select seen last cycle
    } enc_state_t;

endpackage

// File: rtl/upenc_sync.sv
module upenc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < CHAIN; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        if (rst) begin
            chain_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign sync_o = chain_q[CHAIN-1];
endmodule

// File: rtl/upenc_rise.sv
module upenc_rise #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] last_d, last_q;

    always_comb begin
        last_d = rst ? '0 : lvl_i;
    end

    always_ff @(posedge clk) begin
        last_q <= last_d;
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_rise
            assign rise_o[g] = lvl_i[g] & ~last_q[g];
        end
    endgenerate
endmodule

// File: rtl/upenc_clk_div.sv
module upenc_clk_div #(
    parameter int DIV_RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    output logic clk_o,
    output logic tick_o
);
    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV_RATIO / 2);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (rst || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign clk_o  = (cnt_q < HALF);
    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/one_pulse_uplink_enc.sv
module one_pulse_uplink_enc
    import upenc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_RATIO   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_clk_i,
    input  logic       data_i,
    input  logic       ext_pclk_i,
    input  logic [1:0] src_sel_i,
    output logic       clk_div_o,
    output logic       enc_o,
    output logic       overrun_o
);
    logic [N_ASYNC-1:0] raw_vec, sync_vec;
    logic [1:0]         rise_vec;
    logic               div_tick;
    logic               sample_one, ptick, req_left;
    enc_state_t         st_d, st_q;

    assign raw_vec[IDX_DCLK] = data_clk_i;
    assign raw_vec[IDX_DATA] = data_i;
    assign raw_vec[IDX_EXT]  = ext_pclk_i;

    upenc_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .async_i(raw_vec),
        .sync_o (sync_vec)
    );

    upenc_rise #(.WIDTH(2)) rise_i (
        .clk   (clk),
        .rst   (rst),
        .lvl_i ({sync_vec[IDX_EXT], sync_vec[IDX_DCLK]}),
        .rise_o(rise_vec)
    );

    upenc_clk_div #(.DIV_RATIO(DIV_RATIO)) div_i (
        .clk   (clk),
        .rst   (rst),
        .clk_o (clk_div_o),
        .tick_o(div_tick)
    );

    assign sample_one = rise_vec[0] & sync_vec[IDX_DATA];

    always_comb begin
        case (psrc_e'(src_sel_i))
            PSRC_DIV: ptick = div_tick;
            PSRC_EXT: ptick = rise_vec[1];
            default:  ptick = 1'b1;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        req_left = st_q.req;
        st_d.sel = src_sel_i;
        if (src_sel_i != st_q.sel) begin
            st_d.act = 1'b0;
            st_d.req = 1'b0;
        end else begin
            if (ptick) begin
                if (st_q.act) begin
                    st_d.act = 1'b0;
                end else if (st_q.req) begin
                    st_d.act = 1'b1;
                    req_left = 1'b0;
                end
            end
            st_d.req = req_left;
            if (sample_one) begin
                if (req_left) begin
                    st_d.ovr = 1'b1;
                end else begin
                    st_d.req = 1'b1;
                end
            end
        end
        if (rst) begin
            st_d     = '0;
            st_d.sel = src_sel_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign enc_o     = st_q.act;
    assign overrun_o = st_q.ovr;
endmodule

// File: rtl/upenc_checker.sv
module upenc_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] src_sel_i,
    input logic       clk_div_o,
    input logic       enc_o,
    input logic       overrun_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!enc_o && !overrun_o && clk_div_o)); // R1

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o); // R8

    AST_SEL_DROP: assert property (@(posedge clk) disable iff (rst)
        (src_sel_i != $past(src_sel_i)) |=> !enc_o); // R9

    AST_SYS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (enc_o && (src_sel_i[1] == src_sel_i[0])) |=> !enc_o); // R4

    AST_DIV_ALIGN: assert property (@(posedge clk) disable iff (rst)
        ($rose(enc_o) && $past(src_sel_i) == 2'b01) |-> $rose(clk_div_o)); // R5
endmodule

bind one_pulse_uplink_enc upenc_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .src_sel_i(src_sel_i),
    .clk_div_o(clk_div_o),
    .enc_o    (enc_o),
    .overrun_o(overrun_o)
);

// File: tb/one_pulse_uplink_enc_tb_top.sv
`timescale 1ns/1ps
module one_pulse_uplink_enc_tb_top;
    localparam int DIV = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic data_clk_i = 1'b0, data_i = 1'b0, ext_pclk_i = 1'b0;
    logic [1:0] src_sel_i = 2'b00;
    wire clk_div_o, enc_o, overrun_o;

    int total = 0, bad = 0;
    bit started = 0, ext_run = 0, done = 0;
    int ext_div = 0, npulse = 0, width_cur = 0, last_width = 0;
    bit prev_enc = 0;

    // reference model state
    bit m_dc1, m_dc2, m_dc3, m_d1, m_d2, m_ec1, m_ec2, m_ec3;
    bit m_act, m_req, m_ovr;
    bit [1:0] m_sel;
    int m_cnt = 0;

    one_pulse_uplink_enc #(.SYNC_STAGES(2), .DIV_RATIO(DIV)) dut_i (
        .clk(clk), .rst(rst), .data_clk_i(data_clk_i), .data_i(data_i),
        .ext_pclk_i(ext_pclk_i), .src_sel_i(src_sel_i),
        .clk_div_o(clk_div_o), .enc_o(enc_o), .overrun_o(overrun_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, int act, int exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // behavioural model: advances once per rising edge
    always @(posedge clk) begin
        bit samp, tick, rq;
        started = 1;
        if (rst) begin
            {m_dc1, m_dc2, m_dc3, m_d1, m_d2, m_ec1, m_ec2, m_ec3} = '0;
            {m_act, m_req, m_ovr} = '0;
            m_cnt = 0;
            m_sel = src_sel_i;
        end else begin
            samp = m_dc2 && !m_dc3 && m_d2;
            if (src_sel_i == 2'b01)      tick = (m_cnt == DIV - 1);
            else if (src_sel_i == 2'b10) tick = m_ec2 && !m_ec3;
            else                         tick = 1;
            if (src_sel_i != m_sel) begin
                m_act = 0;
                m_req = 0;
            end else begin
                rq = m_req;
                if (tick) begin
                    if (m_act) m_act = 0;
                    else if (m_req) begin m_act = 1; rq = 0; end
                end
                if (samp) begin
                    if (rq) m_ovr = 1;
                    else rq = 1;
                end
                m_req = rq;
            end
            m_sel = src_sel_i;
            m_dc3 = m_dc2; m_dc2 = m_dc1; m_dc1 = data_clk_i;
            m_d2 = m_d1; m_d1 = data_i;
            m_ec3 = m_ec2; m_ec2 = m_ec1; m_ec1 = ext_pclk_i;
            m_cnt = (m_cnt + 1) % DIV;
        end
    end

    // compare against the model and gather pulse statistics
    always @(negedge clk) begin
        if (started) begin
            case (src_sel_i)
                2'b01:   chk("R5", enc_o, m_act, "enc_o vs model");
                2'b10:   chk("R6", enc_o, m_act, "enc_o vs model");
                default: chk("R4", enc_o, m_act, "enc_o vs model");
            endcase
            chk("R2", clk_div_o, (m_cnt < DIV / 2), "clk_div_o vs model");
            chk("R8", overrun_o, m_ovr, "overrun_o vs model");
        end
        if (enc_o === 1'b1 && !prev_enc) npulse++;
        if (enc_o === 1'b1) width_cur++;
        else if (prev_enc) begin last_width = width_cur; width_cur = 0; end
        prev_enc = (enc_o === 1'b1);
        if (ext_run) begin
            ext_div++;
            if (ext_div == 3) begin ext_div = 0; ext_pclk_i = ~ext_pclk_i; end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(bit b, int gap);
        @(negedge clk) data_i = b;
        @(negedge clk) data_clk_i = 1'b1;
        cyc(gap);
        data_clk_i = 1'b0;
        cyc(gap);
    endtask

    task automatic run_pattern(logic [1:0] sel, int gap, int exp_width, string tag);
        src_sel_i = sel;
        cyc(12);
        npulse = 0;
        send(1, gap); send(0, gap); send(1, gap); send(1, gap); send(0, gap);
        cyc(40);
        chk("R3", npulse, 3, "pulse count for 1,0,1,1,0");
        chk(tag, last_width, exp_width, "pulse width in clocks");
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        cyc(3);
        chk("R1", enc_o, 0, "enc_o in reset");
        chk("R1", overrun_o, 0, "overrun_o in reset");
        chk("R1", clk_div_o, 1, "clk_div_o in reset");
        rst = 1'b0;

        run_pattern(2'b00, 6, 1, "R4");
        run_pattern(2'b11, 6, 1, "R4");
        run_pattern(2'b01, 8, DIV, "R5");
        ext_run = 1;
        run_pattern(2'b10, 12, 6, "R6");

        // R7: two ones in quick succession both reach the output
        src_sel_i = 2'b01; cyc(10); npulse = 0;
        send(1, 3); send(1, 3);
        cyc(30);
        chk("R7", npulse, 2, "two close ones give two pulses");
        chk("R7", overrun_o, 0, "no overrun for two ones");

        // R8: a burst of three ones must overflow the single pending slot
        send(1, 1); send(1, 1); send(1, 1);
        cyc(30);
        chk("R8", overrun_o, 1, "overrun after burst");
        cyc(5);
        chk("R8", overrun_o, 1, "overrun stays set");

        // R10: reset in the middle of a run clears the sticky flag
        rst = 1'b1; cyc(2); rst = 1'b0;
        cyc(1);
        chk("R10", overrun_o, 0, "overrun cleared by reset");
        chk("R10", enc_o, 0, "enc_o cleared by reset");

        // R9: select change forces an active pulse low
        src_sel_i = 2'b10; cyc(10);
        send(1, 2);
        for (int i = 0; i < 40 && enc_o !== 1'b1; i++) cyc(1);
        ext_run = 0;
        cyc(3);
        chk("R9", enc_o, 1, "pulse held while external clock stalls");
        src_sel_i = 2'b00;
        cyc(1);
        chk("R9", enc_o, 0, "pulse dropped after select change");

        // R9: a waiting request is discarded on select change
        src_sel_i = 2'b10; cyc(6);
        npulse = 0;
        send(1, 2);
        cyc(8);
        src_sel_i = 2'b00;
        cyc(20);
        chk("R9", npulse, 0, "pending request discarded");
        chk("R3", overrun_o, 0, "no overrun in select test");

        finish_up();
    end
endmodule